// File: doc/BRIEF.md
# Bus Request Channel Stabilizer

This block sits between a transaction source and a request/grant memory bus. Its job is to keep the address-phase fields on the bus steady while a request waits for grant. The source does not have to keep its fields steady. Most of the time the block is a wire. The source's valid, address, write enable, byte enables and write data go straight to the bus in the same cycle, so a run of requests that are granted at once costs no extra cycle.

When the bus refuses a request (request high, grant low), the block stores the whole address channel in a register. From then on it drives the bus only from that copy. It keeps request asserted and holds the source's ready low until grant arrives, and then it goes back to being a wire.

Back-pressure works like this: ready is the acceptance signal, and a source that may change or withdraw its fields while ready is low (parameter `STABLE_REQ` = 0) must watch ready to know whether its transaction was taken. A transaction offered during the cycle in which a stored request is granted is not taken, because ready is low in that cycle. With `STABLE_REQ` = 1 the source promises stable requests, and the block reduces to plain wires. Read-response signals always pass from the bus to the source without registers.

Top module: `bus_req_stabilizer`

## Requirements
- R1: After a synchronous active-low reset, including a reset applied while a request is held, the block is in the transparent state. With upstream valid low, bus request is low and the bus fields equal the upstream fields.
- R2: In the transparent state, bus request equals upstream valid and the bus address, write enable, byte enables and write data equal the upstream fields in the same cycle, so immediately granted back-to-back requests see zero added latency.
- R3: In the transparent state, upstream ready equals the bus grant input in the same cycle.
- R4: When a request is refused in the transparent state (upstream valid high, grant low), the next cycle the bus carries the refused fields with request high, whatever the upstream fields or valid now are.
- R5: In every cycle that follows a cycle with bus request high and grant low, upstream ready is low.
- R6: A held request stays on the bus until grant. On the grant cycle the bus still shows the stored fields, and the next cycle the block is transparent again. An upstream transaction offered during that grant cycle is not captured: the bus then follows the upstream fields directly.
- R7: With `STABLE_REQ` = 0, the bus fields and bus request do not change from a cycle with request high and grant low to the next cycle.
- R8: Read valid, read data and error go from the bus side to the upstream side combinationally in the same cycle.
- R9: With `STABLE_REQ` = 1, bus outputs always equal the upstream inputs and upstream ready always equals grant, even after a refused request.
- R10: Each bus handshake (request and grant both high) carries exactly the fields of one upstream transaction, in the order the transactions were offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upstream transaction valid |
| up_ready | output | 1 | Upstream transaction accepted this cycle |
| up_addr | input | ADDR_W | Upstream address |
| up_we | input | 1 | Upstream write enable |
| up_be | input | DATA_W/8 | Upstream byte enables |
| up_wdata | input | DATA_W | Upstream write data |
| up_rvalid | output | 1 | Response valid to upstream |
| up_rdata | output | DATA_W | Read data to upstream |
| up_err | output | 1 | Response error to upstream |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | ADDR_W | Bus address |
| bus_we | output | 1 | Bus write enable |
| bus_be | output | DATA_W/8 | Bus byte enables |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rvalid | input | 1 | Response valid from bus |
| bus_rdata | input | DATA_W | Read data from bus |
| bus_err | input | 1 | Response error from bus |

## Verification
The hardest situation to reach is the grant cycle of a held request. In that cycle the stored copy must reach the bus while a different upstream transaction is offered, and the next cycle must show that this transaction was dropped, not captured. The stimulus reaches it in stages. It refuses a request and then scrambles or withdraws the upstream fields over several stall cycles. It then grants while a fresh transaction is offered, and on the following cycle lowers valid and grant so that the bus fields show plainly which copy is driving them. A scoreboard compares every bus handshake against the queue of transactions the driver expected to be taken. A second instance with stable requests promised sees the same stimulus and is checked as pure wiring.

// File: rtl/bstab_pkg.sv
package bstab_pkg;
  typedef enum logic {
    ST_PASS = 1'b0,
    ST_HOLD = 1'b1
  } bstab_state_e;
endpackage

// File: rtl/bstab_ctrl.sv
module bstab_ctrl
  import bstab_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  input  logic         bus_gnt,
  output bstab_state_e state,
  output logic         cap_en
);
  bstab_state_e st_q;

  assign cap_en = (st_q == ST_PASS) && up_valid && !bus_gnt;
  assign state  = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_PASS;
    end else begin
      case (st_q)
        ST_PASS: if (up_valid && !bus_gnt) st_q <= ST_HOLD;
        ST_HOLD: if (bus_gnt)              st_q <= ST_PASS;
        default:                           st_q <= ST_PASS;
      endcase
    end
  end

  AST_ENTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PASS && up_valid && !bus_gnt) |=> (st_q == ST_HOLD)); // R4
  AST_BACK_TO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && bus_gnt) |=> (st_q == ST_PASS)); // R6
  AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !bus_gnt) |=> (st_q == ST_HOLD)); // R6
endmodule

// File: rtl/bstab_hold.sv
module bstab_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/bstab_mux.sv
module bstab_mux #(
  parameter int unsigned W = 8
) (
  input  logic         held_sel,
  input  logic [W-1:0] up_ch,
  input  logic [W-1:0] held_ch,
  input  logic         up_valid,
  input  logic         bus_gnt,
  output logic [W-1:0] bus_ch,
  output logic         bus_req,
  output logic         up_ready
);
  always_comb begin
    if (held_sel) begin
      bus_ch   = held_ch;
      bus_req  = 1'b1;
      up_ready = 1'b0;
    end else begin
      bus_ch   = up_ch;
      bus_req  = up_valid;
      up_ready = bus_gnt;
    end
  end
endmodule

// File: rtl/bus_req_stabilizer.sv
module bus_req_stabilizer
  import bstab_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter bit          STABLE_REQ = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [ADDR_W-1:0]   up_addr,
  input  logic                up_we,
  input  logic [DATA_W/8-1:0] up_be,
  input  logic [DATA_W-1:0]   up_wdata,
  output logic                up_rvalid,
  output logic [DATA_W-1:0]   up_rdata,
  output logic                up_err,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_we,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rvalid,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_err
);
  localparam int unsigned BE_W = DATA_W / 8;
  localparam int unsigned CH_W = ADDR_W + 1 + BE_W + DATA_W;

  logic [CH_W-1:0] up_ch;
  logic [CH_W-1:0] bus_ch;

  assign up_ch = {up_addr, up_we, up_be, up_wdata};
  assign {bus_addr, bus_we, bus_be, bus_wdata} = bus_ch;

  // response phase: straight through
  assign up_rvalid = bus_rvalid;
  assign up_rdata  = bus_rdata;
  assign up_err    = bus_err;

  generate
    if (STABLE_REQ) begin : g_wire
      assign bus_ch   = up_ch;
      assign bus_req  = up_valid;
      assign up_ready = bus_gnt;
    end else begin : g_stab
      bstab_state_e    state;
      logic            cap_en;
      logic [CH_W-1:0] held_ch;

      bstab_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .bus_gnt  (bus_gnt),
        .state    (state),
        .cap_en   (cap_en)
      );

      bstab_hold #(.W(CH_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .d      (up_ch),
        .q      (held_ch)
      );

      bstab_mux #(.W(CH_W)) u_mux (
        .held_sel (state == ST_HOLD),
        .up_ch    (up_ch),
        .held_ch  (held_ch),
        .up_valid (up_valid),
        .bus_gnt  (bus_gnt),
        .bus_ch   (bus_ch),
        .bus_req  (bus_req),
        .up_ready (up_ready)
      );

      AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_ch))); // R7
      AST_NO_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> !up_ready); // R5
      AST_REFUSED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && bus_req && !bus_gnt) |=> (bus_ch == $past(up_ch))); // R4
    end
  endgenerate
endmodule

// File: tb/tb_bus_req_stabilizer.sv
module tb_bus_req_stabilizer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int CW = AW + 1 + BW + DW;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic          up_valid, up_we, bus_gnt, bus_rvalid, bus_err;
  logic [AW-1:0] up_addr;
  logic [BW-1:0] up_be;
  logic [DW-1:0] up_wdata, bus_rdata;

  logic          up_ready, up_rvalid, up_err, bus_req, bus_we;
  logic [DW-1:0] up_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic [BW-1:0] bus_be;

  logic          p_ready, p_rvalid, p_err, p_req, p_we;
  logic [DW-1:0] p_rdata, p_wdata;
  logic [AW-1:0] p_addr;
  logic [BW-1:0] p_be;

  bus_req_stabilizer #(.ADDR_W(AW), .DATA_W(DW), .STABLE_REQ(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_we(up_we), .up_be(up_be), .up_wdata(up_wdata),
    .up_rvalid(up_rvalid), .up_rdata(up_rdata), .up_err(up_err),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err));

  bus_req_stabilizer #(.ADDR_W(AW), .DATA_W(DW), .STABLE_REQ(1'b1)) dut_pass (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(p_ready),
    .up_addr(up_addr), .up_we(up_we), .up_be(up_be), .up_wdata(up_wdata),
    .up_rvalid(p_rvalid), .up_rdata(p_rdata), .up_err(p_err),
    .bus_req(p_req), .bus_gnt(bus_gnt), .bus_addr(p_addr), .bus_we(p_we),
    .bus_be(p_be), .bus_wdata(p_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err));

  int errors = 0;
  int checks = 0;
  logic [CW-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] up_item();
    return {up_addr, up_we, up_be, up_wdata};
  endfunction

  function automatic logic [CW-1:0] bus_item();
    return {bus_addr, bus_we, bus_be, bus_wdata};
  endfunction

  task automatic drive(input logic v, input logic [AW-1:0] a, input logic g);
    up_valid = v;
    up_addr  = a;
    up_we    = a[0];
    up_be    = a[7:4];
    up_wdata = ~a ^ 32'h5A5A_0000;
    bus_gnt  = g;
  endtask

  // scoreboard monitor: bus handshakes (R10), pass-through twin (R9), responses (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && bus_gnt) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected handshake", bus_item(), '0);
        else begin
          logic [CW-1:0] e;
          e = exp_q.pop_front();
          check(bus_item() == e, "R10 handshake item", bus_item(), e);
        end
      end
      check({p_addr, p_we, p_be, p_wdata} == up_item() && p_req == up_valid &&
            p_ready == bus_gnt, "R9 stable-request pass-through",
            {p_addr, p_we, p_be, p_wdata}, up_item());
      check(up_rvalid == bus_rvalid && up_rdata == bus_rdata && up_err == bus_err,
            "R8 response forward", {up_rvalid, up_err, up_rdata},
            {bus_rvalid, bus_err, bus_rdata});
    end
  end

  // response stimulus toggles independently
  always @(posedge clk) begin
    #1;
    bus_rvalid <= $urandom_range(0, 1);
    bus_err    <= $urandom_range(0, 1);
    bus_rdata  <= $urandom;
  end

  task automatic send_granted(input logic [AW-1:0] a);
    @(posedge clk); #1;
    drive(1'b1, a, 1'b1);
    exp_q.push_back(up_item());
    @(negedge clk);
    check(bus_item() == up_item() && bus_req, "R2 transparent same cycle", bus_item(), up_item());
    check(up_ready == 1'b1, "R3 ready follows grant", {{(CW-1){1'b0}}, up_ready}, 1);
  endtask

  task automatic send_refused(input logic [AW-1:0] a, input int waits,
                              input logic [AW-1:0] late);
    logic [CW-1:0] held;
    @(posedge clk); #1;
    drive(1'b1, a, 1'b0);
    held = up_item();
    exp_q.push_back(held);
    @(negedge clk);
    check(up_ready == 1'b0, "R3 ready low with grant low", {{(CW-1){1'b0}}, up_ready}, 0);
    for (int i = 0; i < waits; i++) begin
      @(posedge clk); #1;
      drive(i[0], a ^ (32'h1111_1111 * (i + 1)), 1'b0);
      @(negedge clk);
      check(bus_item() == held && bus_req, "R4 refused fields held", bus_item(), held);
      check(up_ready == 1'b0, "R5 ready low while held", {{(CW-1){1'b0}}, up_ready}, 0);
      check(bus_item() == held, "R7 fields stable while waiting", bus_item(), held);
    end
    @(posedge clk); #1;
    drive(1'b1, late, 1'b1);
    @(negedge clk);
    check(bus_item() == held && up_ready == 1'b0, "R6 grant cycle uses stored copy",
          bus_item(), held);
    @(posedge clk); #1;
    drive(1'b0, late ^ 32'h0F0F_0F0F, 1'b0);
    @(negedge clk);
    check(bus_item() == up_item() && !bus_req, "R6 late transaction not captured",
          bus_item(), up_item());
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bus_rvalid = 0; bus_err = 0; bus_rdata = 0;
    drive(1'b0, 32'h0, 1'b0);
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    drive(1'b0, 32'hABCD_0123, 1'b0);
    @(negedge clk);
    check(!bus_req && bus_item() == up_item(), "R1 reset state transparent", bus_item(), up_item());

    // back-to-back granted burst
    for (int k = 0; k < 6; k++) send_granted(32'h1000_0000 + k * 32'h10);
    // refused requests with various stall lengths
    send_refused(32'h7453_6030, 3, 32'hCC3B_C3F0);
    send_refused(32'h2222_0040, 1, 32'h3333_0050);
    send_granted(32'h4444_0060);
    send_refused(32'h5555_0070, 6, 32'h6666_0080);
    for (int k = 0; k < 3; k++) send_granted(32'h9000_0000 + k * 32'h20);

    // reset while a request is held
    @(posedge clk); #1;
    drive(1'b1, 32'hDEAD_00F0, 1'b0);
    @(posedge clk); #1;
    rst_n = 0;
    drive(1'b0, 32'hBEEF_0010, 1'b0);
    exp_q.delete();
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(!bus_req && bus_item() == up_item(), "R1 reset from held state",
          bus_item(), up_item());
    check(up_ready == bus_gnt, "R1 ready after reset", {{(CW-1){1'b0}}, up_ready},
          {{(CW-1){1'b0}}, bus_gnt});
    send_granted(32'hA5A5_0030);

    @(posedge clk); #1;
    drive(1'b0, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10 all expected items seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule